// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Condition Flags

This block is the arithmetic unit of a 16-bit RISC core's execute stage. It takes an instruction class, a 4-bit function code, two 16-bit operands and an immediate field. It returns a registered 16-bit result one clock later. The block also holds the zero, negative, carry and overflow flags. Each operation rewrites only the flags it is defined to affect, and every other flag keeps its value. The carry flag feeds the add-with-carry, subtract-with-borrow and rotate operations.

Next to the datapath, a branch evaluator compares a 3-bit condition code with the flags currently held and drives a combinational taken signal. The same unit handles the add-immediate and load-upper-immediate forms. For memory-access instructions it is a pass-through that leaves the flags alone. The register file, operand bypass and program-counter logic sit outside the block.

Top module: `exu_alu`

## Requirements
- R1: Class 0 (register form) function codes 0 AND, 1 OR, 6 XOR and 7 NOT (NOT inverts `in_a`) produce the bitwise result and update only N and Z. The flags vector uses bit 0 Z, bit 1 N, bit 2 C, bit 3 O. N is result bit 15 and Z is set when the result is zero.
- R2: Function code 2 shifts `in_a` left by one and code 3 shifts it right by one, filling with zero. C takes the bit shifted out, N and Z follow the result, and O is unchanged.
- R3: Function codes 4 add, 5 subtract, 12 add with carry-in C and 13 subtract with borrow-in C update all four flags. For additions C is the carry out. For subtractions C is set when a borrow occurs. O is set on two's-complement overflow.
- R4: Function code 10 rotates `in_a` left, with the old C entering bit 0. Code 11 rotates it right, with the old C entering bit 15. Both update only N and Z, so C and O are unchanged.
- R5: Class 1 (add-immediate) adds `in_a` to `in_imm[5:0]` read as a two's-complement value and updates only N and Z.
- R6: Class 2 (load-upper-immediate) returns `in_imm[9:0]` in result bits 15..6 with bits 5..0 cleared, and leaves all flags unchanged.
- R7: Class 0 function codes 8, 9, 14 and 15 return a zero result and leave all flags unchanged.
- R8: Class 3 (memory access) returns a zero result and leaves the flags unchanged. A cycle with `in_valid` low leaves the flags unchanged and gives `out_valid` low on the next cycle.
- R9: `br_taken` compares `br_cond` with the flags currently held. Codes 0..3 mean Z, N, C or O is set, and codes 4..7 mean the same flag is clear. In a cycle that also issues a flag-changing operation, the flags from before that edge are used.
- R10: When `in_valid` is high at a rising edge, `out_result`, the new flags and `out_valid` appear after that edge. When `in_valid` is low, `out_result` holds its value.
- R11: A synchronous active-low reset clears the flags, `out_result` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 2 | Class: 0 register, 1 add-immediate, 2 load-upper-immediate, 3 memory access |
| in_op | input | 4 | Function code for class 0 |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_imm | input | 10 | Immediate field |
| br_cond | input | 3 | Branch condition code |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 16 | Registered result |
| flags | output | 4 | Held flags: bit 0 Z, 1 N, 2 C, 3 O |
| br_taken | output | 1 | Condition code satisfied by held flags |

## Verification
The branch evaluator and a flag update can fall in the same cycle: an operation that flips a flag is issued while `br_cond` tests that same flag. The bench samples `br_taken` before the edge and expects the verdict from the old flags. It then holds the condition over an idle cycle and expects the verdict from the new flags. The scoreboard keeps its own flag model, so carry chains through rotates, adds with carry-in and subtracts with borrow-in are followed across consecutive operations, and a random stream mixes both functions.

// File: rtl/exu_alu_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the execute-stage arithmetic unit.
// Assumes flags are packed as a 4-bit vector indexed by the FLAG_* constants.
package exu_alu_pkg;

    // Instruction class presented on in_kind.
    typedef enum logic [1:0] {
        KIND_REG  = 2'd0,
        KIND_ADDI = 2'd1,
        KIND_LUI  = 2'd2,
        KIND_MEM  = 2'd3
    } exu_kind_e;

    localparam int NUM_FLAGS = 4;
    localparam int FLAG_Z    = 0;
    localparam int FLAG_N    = 1;
    localparam int FLAG_C    = 2;
    localparam int FLAG_O    = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    // Class 0 function codes.
    localparam logic [3:0] OP_AND = 4'd0;
    localparam logic [3:0] OP_OR  = 4'd1;
    localparam logic [3:0] OP_SHL = 4'd2;
    localparam logic [3:0] OP_SHR = 4'd3;
    localparam logic [3:0] OP_ADD = 4'd4;
    localparam logic [3:0] OP_SUB = 4'd5;
    localparam logic [3:0] OP_XOR = 4'd6;
    localparam logic [3:0] OP_NOT = 4'd7;
    localparam logic [3:0] OP_ROL = 4'd10;
    localparam logic [3:0] OP_ROR = 4'd11;
    localparam logic [3:0] OP_ADC = 4'd12;
    localparam logic [3:0] OP_SBC = 4'd13;

    // Which flags an operation is allowed to rewrite.
    localparam flag_vec_t UPD_NONE = 4'b0000;
    localparam flag_vec_t UPD_NZ   = 4'b0011;
    localparam flag_vec_t UPD_CNZ  = 4'b0111;
    localparam flag_vec_t UPD_ALL  = 4'b1111;

endpackage

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
// Module: alu_adder
// Shared add/subtract datapath. Subtraction is done as a + ~b + carry-in.
// Assumes: for subtract, carry_flag reports borrow (inverse of raw carry out);
// use_cin selects carry-in C (add) or borrow-in C (subtract).
module alu_adder #(
    parameter int DW = 16
) (
    input  logic          sub,
    input  logic          use_cin,
    input  logic          cin,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry_flag,
    output logic          ovf
);
    logic [DW-1:0] b_eff;
    logic          c0;
    logic [DW:0]   wide;

    // Select the second operand polarity and the raw carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        if (sub) c0 = use_cin ? ~cin : 1'b1;
        else     c0 = use_cin ?  cin : 1'b0;
    end

    // Form the sum, carry/borrow and signed overflow.
    always_comb begin
        wide       = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c0};
        sum        = wide[DW-1:0];
        carry_flag = sub ? ~wide[DW] : wide[DW];
        ovf        = (a[DW-1] == b_eff[DW-1]) && (wide[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu_logic_shift.sv
`timescale 1ns/1ps
// Module: alu_logic_shift
// Bitwise operations, one-place shifts and rotates through carry.
// Assumes: op is a class 0 function code; codes it does not own return zero.
module alu_logic_shift
    import exu_alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    op,
    input  logic          cin,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          shift_out
);
    // Select the logic, shift or rotate result and the bit moved out.
    always_comb begin
        res       = '0;
        shift_out = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res       = {a[DW-2:0], 1'b0};
                shift_out = a[DW-1];
            end
            OP_SHR: begin
                res       = {1'b0, a[DW-1:1]};
                shift_out = a[0];
            end
            OP_ROL: res = {a[DW-2:0], cin};
            OP_ROR: res = {cin, a[DW-1:1]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
// Module: alu_core
// Combinational operation unit: picks the result and the candidate flag values
// plus a mask naming the flags the operation is allowed to rewrite.
// Assumes: ADDI_W <= IMM_W and IMM_W < DW; the immediate field is right-aligned.
module alu_core
    import exu_alu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int IMM_W  = 10,
    parameter int ADDI_W = 6
) (
    input  exu_kind_e        kind,
    input  logic [3:0]       op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [IMM_W-1:0] imm,
    input  flag_vec_t        cur_flags,
    output logic [DW-1:0]    res,
    output flag_vec_t        new_flags,
    output flag_vec_t        upd_mask
);
    localparam int LOW_W = DW - IMM_W;

    logic          is_arith;
    logic          use_adder;
    logic          add_sub;
    logic          add_cin;
    logic [DW-1:0] add_b;
    logic [DW-1:0] add_sum;
    logic          add_c;
    logic          add_o;
    logic [DW-1:0] ls_res;
    logic          ls_out;
    logic [DW-1:0] addi_ext;

    // Sign-extend the add-immediate field to the datapath width.
    always_comb begin
        addi_ext = {{(DW-ADDI_W){imm[ADDI_W-1]}}, imm[ADDI_W-1:0]};
    end

    // Decide how the shared adder is driven for this operation.
    always_comb begin
        is_arith  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) || (op == OP_SBC);
        use_adder = (kind == KIND_ADDI) || ((kind == KIND_REG) && is_arith);
        add_sub   = (kind == KIND_REG) && ((op == OP_SUB) || (op == OP_SBC));
        add_cin   = (kind == KIND_REG) && ((op == OP_ADC) || (op == OP_SBC));
        add_b     = (kind == KIND_ADDI) ? addi_ext : b;
    end

    alu_adder #(.DW(DW)) u_adder (
        .sub        (add_sub),
        .use_cin    (add_cin),
        .cin        (cur_flags[FLAG_C]),
        .a          (a),
        .b          (add_b),
        .sum        (add_sum),
        .carry_flag (add_c),
        .ovf        (add_o)
    );

    alu_logic_shift #(.DW(DW)) u_logic (
        .op        (op),
        .cin       (cur_flags[FLAG_C]),
        .a         (a),
        .b         (b),
        .res       (ls_res),
        .shift_out (ls_out)
    );

    // Choose the result and the update mask per class and function code.
    always_comb begin
        res      = '0;
        upd_mask = UPD_NONE;
        unique case (kind)
            KIND_REG: begin
                if (use_adder) begin
                    res      = add_sum;
                    upd_mask = UPD_ALL;
                end else begin
                    res = ls_res;
                    unique case (op)
                        OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ROL, OP_ROR: upd_mask = UPD_NZ;
                        OP_SHL, OP_SHR:                                upd_mask = UPD_CNZ;
                        default:                                       upd_mask = UPD_NONE;
                    endcase
                end
            end
            KIND_ADDI: begin
                res      = add_sum;
                upd_mask = UPD_NZ;
            end
            KIND_LUI: begin
                res      = {imm, {LOW_W{1'b0}}};
                upd_mask = UPD_NONE;
            end
            default: begin
                res      = '0;
                upd_mask = UPD_NONE;
            end
        endcase
    end

    // Candidate flag values; the mask decides which of them are kept.
    always_comb begin
        new_flags         = cur_flags;
        new_flags[FLAG_Z] = (res == '0);
        new_flags[FLAG_N] = res[DW-1];
        new_flags[FLAG_C] = use_adder ? add_c : ls_out;
        new_flags[FLAG_O] = add_o;
    end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
// Module: alu_flag_reg
// Condition flag storage with per-flag write enables.
// Assumes: synchronous active-low reset clears every flag.
module alu_flag_reg
    import exu_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  flag_vec_t mask,
    input  flag_vec_t nxt,
    output flag_vec_t q
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        // Hold or rewrite flag i.
        always_ff @(posedge clk) begin
            if (!rst_n)               q[i] <= 1'b0;
            else if (en && mask[i])   q[i] <= nxt[i];
        end
    end

    // Flags outside the mask must not move.
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hold_chk
        assert_masked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !mask[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/alu_cond_eval.sv
`timescale 1ns/1ps
// Module: alu_cond_eval
// Branch condition evaluator. Low two code bits pick the flag, the top bit
// inverts the test (set vs clear).
// Assumes: flags are the registered values, so the verdict uses pre-update state.
module alu_cond_eval
    import exu_alu_pkg::*;
(
    input  flag_vec_t  cur_flags,
    input  logic [2:0] cond,
    output logic       taken
);
    logic [2*NUM_FLAGS-1:0] hit;

    for (genvar k = 0; k < 2*NUM_FLAGS; k++) begin : g_hit
        // Condition k tests flag k mod 4, clear when k >= 4.
        always_comb hit[k] = cur_flags[k % NUM_FLAGS] ^ (k >= NUM_FLAGS);
    end

    // Select the verdict for the presented code.
    always_comb taken = hit[cond];
endmodule

// File: rtl/exu_alu.sv
`timescale 1ns/1ps
// Module: exu_alu (top)
// Execute-stage arithmetic unit: registered result, held condition flags and
// a combinational branch verdict on the held flags.
// Assumes: one operation per cycle when in_valid is high; synchronous
// active-low reset.
module exu_alu
    import exu_alu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int IMM_W  = 10,
    parameter int ADDI_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [3:0]       in_op,
    input  logic [DW-1:0]    in_a,
    input  logic [DW-1:0]    in_b,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [2:0]       br_cond,
    output logic             out_valid,
    output logic [DW-1:0]    out_result,
    output logic [3:0]       flags,
    output logic             br_taken
);
    localparam int LOW_W = DW - IMM_W;

    exu_kind_e     kind;
    logic [DW-1:0] core_res;
    flag_vec_t     core_flags;
    flag_vec_t     core_mask;
    flag_vec_t     flag_q;

    always_comb kind = exu_kind_e'(in_kind);

    alu_core #(.DW(DW), .IMM_W(IMM_W), .ADDI_W(ADDI_W)) u_core (
        .kind      (kind),
        .op        (in_op),
        .a         (in_a),
        .b         (in_b),
        .imm       (in_imm),
        .cur_flags (flag_q),
        .res       (core_res),
        .new_flags (core_flags),
        .upd_mask  (core_mask)
    );

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .mask  (core_mask),
        .nxt   (core_flags),
        .q     (flag_q)
    );

    alu_cond_eval u_cond (
        .cur_flags (flag_q),
        .cond      (br_cond),
        .taken     (br_taken)
    );

    // Capture the result on each valid operation; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= core_res;
        end
    end

    always_comb flags = flag_q;

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(flags)));
    assert_mem_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_MEM) |=> ($stable(flags) && out_result == '0));
    assert_lui_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_LUI) |=> (out_result[LOW_W-1:0] == '0 && $stable(flags)));
    assert_shl_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_REG && in_op == OP_SHL) |=> (flags[FLAG_C] == $past(in_a[DW-1])));
    assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_REG && in_op == OP_SUB) |=> (flags[FLAG_C] == ($past(in_a) < $past(in_b))));
    assert_rot_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_REG && (in_op == OP_ROL || in_op == OP_ROR)) |=> $stable(flags[FLAG_C]));
    assert_undef_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == KIND_REG && (in_op == 4'd8 || in_op == 4'd9 || in_op == 4'd14 || in_op == 4'd15))
        |=> (out_result == '0 && $stable(flags)));
endmodule

// File: tb/sim_exu_alu.sv
`timescale 1ns/1ps
module sim_exu_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'd0;
    logic [3:0]  in_op = 4'd0;
    logic [15:0] in_a = 16'd0;
    logic [15:0] in_b = 16'd0;
    logic [9:0]  in_imm = 10'd0;
    logic [2:0]  br_cond = 3'd0;
    logic        out_valid;
    logic [15:0] out_result;
    logic [3:0]  flags;
    logic        br_taken;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic        v;
        logic [15:0] r;
        logic [3:0]  f;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [3:0] mflags = 4'd0;  // bench flag model: 0 Z,1 N,2 C,3 O

    exu_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
        .br_cond(br_cond), .out_valid(out_valid), .out_result(out_result),
        .flags(flags), .br_taken(br_taken)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of one operation, written from the requirements.
    task automatic model(input logic [1:0] kind, input logic [3:0] op,
                         input logic [15:0] a, input logic [15:0] b, input logic [9:0] imm,
                         input logic [3:0] fin, output logic [15:0] r, output logic [3:0] fo);
        logic [16:0] t;
        logic c, o, upd_nz, upd_c, upd_o;
        logic [15:0] se;
        r = 16'd0; c = fin[2]; o = fin[3];
        upd_nz = 0; upd_c = 0; upd_o = 0;
        case (kind)
            2'd0: case (op)
                4'd0: begin r = a & b; upd_nz = 1; end
                4'd1: begin r = a | b; upd_nz = 1; end
                4'd6: begin r = a ^ b; upd_nz = 1; end
                4'd7: begin r = ~a; upd_nz = 1; end
                4'd2: begin r = a << 1; c = a[15]; upd_nz = 1; upd_c = 1; end
                4'd3: begin r = a >> 1; c = a[0]; upd_nz = 1; upd_c = 1; end
                4'd10: begin r = (a << 1) | {15'd0, fin[2]}; upd_nz = 1; end
                4'd11: begin r = (a >> 1) | {fin[2], 15'd0}; upd_nz = 1; end
                4'd4, 4'd12: begin
                    t = {1'b0, a} + {1'b0, b} + ((op == 4'd12) ? {16'd0, fin[2]} : 17'd0);
                    r = t[15:0]; c = t[16];
                    o = (a[15] == b[15]) && (r[15] != a[15]);
                    upd_nz = 1; upd_c = 1; upd_o = 1;
                end
                4'd5, 4'd13: begin
                    t = {1'b0, a} - {1'b0, b} - ((op == 4'd13) ? {16'd0, fin[2]} : 17'd0);
                    r = t[15:0]; c = t[16];
                    o = (a[15] != b[15]) && (r[15] != a[15]);
                    upd_nz = 1; upd_c = 1; upd_o = 1;
                end
                default: r = 16'd0;
            endcase
            2'd1: begin
                se = {{10{imm[5]}}, imm[5:0]};
                r = a + se; upd_nz = 1;
            end
            2'd2: r = {imm, 6'd0};
            default: r = 16'd0;
        endcase
        fo = fin;
        if (upd_nz) begin fo[0] = (r == 16'd0); fo[1] = r[15]; end
        if (upd_c) fo[2] = c;
        if (upd_o) fo[3] = o;
    endtask

    function automatic logic cond_ok(input logic [2:0] cd, input logic [3:0] f);
        return cd[2] ? ~f[cd[1:0]] : f[cd[1:0]];
    endfunction

    // Driver: present one operation, check the branch verdict on the old flags,
    // push the expected result and advance to the next falling edge.
    task automatic issue(input logic [1:0] kind, input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [9:0] imm, input logic [2:0] cd,
                         input string tag);
        exp_t e;
        logic [15:0] r;
        logic [3:0] fo;
        in_valid = 1'b1; in_kind = kind; in_op = op; in_a = a; in_b = b; in_imm = imm; br_cond = cd;
        #1;
        check(br_taken == cond_ok(cd, mflags), "R9 pre-edge verdict", {31'd0, br_taken}, {31'd0, cond_ok(cd, mflags)});
        model(kind, op, a, b, imm, mflags, r, fo);
        e.v = 1'b1; e.r = r; e.f = fo; e.tag = tag;
        sb.push_back(e);
        mflags = fo;
        @(negedge clk);
    endtask

    task automatic idle(input logic [2:0] cd);
        exp_t e;
        in_valid = 1'b0; in_a = 16'hDEAD; in_op = 4'd4; br_cond = cd;
        #1;
        check(br_taken == cond_ok(cd, mflags), "R9 idle verdict", {31'd0, br_taken}, {31'd0, cond_ok(cd, mflags)});
        e.v = 1'b0; e.r = 16'd0; e.f = mflags; e.tag = "R8 idle";
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare each registered outcome just after its edge.
    always @(posedge clk) begin
        if (running) begin
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(out_valid == e.v, {e.tag, " / R10 valid"}, {31'd0, out_valid}, {31'd0, e.v});
                check(flags == e.f, {e.tag, " flags"}, {28'd0, flags}, {28'd0, e.f});
                if (e.v) check(out_result == e.r, {e.tag, " result"}, {16'd0, out_result}, {16'd0, e.r});
            end
        end
    end

    task automatic do_reset();
        running = 1'b0;
        rst_n = 1'b0;
        in_valid = 1'b1; in_kind = 2'd0; in_op = 4'd7; in_a = 16'h0000;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset valid", {31'd0, out_valid}, 32'd0);
        check(out_result == 16'd0, "R11 reset result", {16'd0, out_result}, 32'd0);
        check(flags == 4'd0, "R11 reset flags", {28'd0, flags}, 32'd0);
        mflags = 4'd0;
        in_valid = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 logic group
        issue(0, 4'd0, 16'hF0F0, 16'h3C3C, 0, 3'd0, "R1 and");
        issue(0, 4'd1, 16'h00F0, 16'h0F00, 0, 3'd0, "R1 or");
        issue(0, 4'd6, 16'h5A5A, 16'h5A5A, 0, 3'd0, "R1 xor zero");
        issue(0, 4'd7, 16'h0000, 16'h1234, 0, 3'd4, "R1 not");
        // R2 shifts set C
        issue(0, 4'd2, 16'h8000, 16'h0, 0, 3'd1, "R2 shl carry out");
        issue(0, 4'd3, 16'h0001, 16'h0, 0, 3'd2, "R2 shr carry out");
        // R4 rotates through C=1, then C=0
        issue(0, 4'd10, 16'h0001, 16'h0, 0, 3'd2, "R4 rol with C");
        issue(0, 4'd11, 16'h0002, 16'h0, 0, 3'd6, "R4 ror with C");
        issue(0, 4'd3, 16'h0002, 16'h0, 0, 3'd2, "R2 shr clear C");
        issue(0, 4'd10, 16'h8001, 16'h0, 0, 3'd6, "R4 rol without C");
        issue(0, 4'd11, 16'h0001, 16'h0, 0, 3'd6, "R4 ror to zero");
        // R3 arithmetic
        issue(0, 4'd4, 16'h7FFF, 16'h0001, 0, 3'd3, "R3 add overflow");
        issue(0, 4'd4, 16'hFFFF, 16'h0001, 0, 3'd7, "R3 add carry");
        issue(0, 4'd12, 16'h0001, 16'h0001, 0, 3'd2, "R3 adc with C");
        issue(0, 4'd5, 16'h0000, 16'h0001, 0, 3'd0, "R3 sub borrow");
        issue(0, 4'd13, 16'h0005, 16'h0003, 0, 3'd2, "R3 sbc with borrow");
        issue(0, 4'd5, 16'h8000, 16'h0001, 0, 3'd3, "R3 sub overflow");
        issue(0, 4'd13, 16'h0005, 16'h0003, 0, 3'd6, "R3 sbc no borrow");
        // R5 add-immediate keeps C and O
        issue(0, 4'd5, 16'h0000, 16'h0001, 0, 3'd2, "R3 set borrow");
        issue(1, 4'd0, 16'h0010, 16'h0, 10'h01F, 3'd2, "R5 addi +31");
        issue(1, 4'd0, 16'h001F, 16'h0, 10'h021, 3'd0, "R5 addi -31");
        issue(1, 4'd0, 16'h0000, 16'h0, 10'h3FF, 3'd1, "R5 addi -1");
        // R6 lui
        issue(2, 4'd0, 16'h1234, 16'h0, 10'h2A5, 3'd1, "R6 lui");
        issue(2, 4'd0, 16'h0, 16'h0, 10'h000, 3'd0, "R6 lui zero");
        // R7 undefined codes with nonzero flags
        issue(0, 4'd4, 16'h7FFF, 16'h8001, 0, 3'd0, "R3 prep flags");
        issue(0, 4'd8, 16'hFFFF, 16'hFFFF, 0, 3'd0, "R7 op8");
        issue(0, 4'd9, 16'h0001, 16'h0002, 0, 3'd2, "R7 op9");
        issue(0, 4'd14, 16'h8000, 16'h8000, 0, 3'd4, "R7 op14");
        issue(0, 4'd15, 16'h1234, 16'h4321, 0, 3'd6, "R7 op15");
        // R8 memory class and idle
        issue(3, 4'd4, 16'h0000, 16'h0000, 10'h3FF, 3'd0, "R8 mem");
        issue(3, 4'd5, 16'h0000, 16'h0001, 0, 3'd4, "R8 mem sub code");
        idle(3'd0); idle(3'd2);
        // R9 full condition sweep in two flag states
        for (int cd = 0; cd < 8; cd++) idle(cd[2:0]);
        issue(0, 4'd5, 16'h8000, 16'h0001, 0, 3'd0, "R3 flag state B");
        for (int cd = 0; cd < 8; cd++) idle(cd[2:0]);
        // R9 same-cycle: flip Z while testing Z
        issue(0, 4'd6, 16'h1111, 16'h1111, 0, 3'd0, "R9 same-cycle set Z");
        idle(3'd0);
        issue(0, 4'd1, 16'h0001, 16'h0000, 0, 3'd4, "R9 same-cycle clear Z");
        idle(3'd4);
        // R10 back-to-back with result hold over idle
        issue(0, 4'd4, 16'h0100, 16'h0023, 0, 3'd1, "R10 b2b 1");
        issue(0, 4'd4, 16'h0200, 16'h0023, 0, 3'd1, "R10 b2b 2");
        idle(3'd1);
        #1 check(out_result == 16'h0223, "R10 hold result", {16'd0, out_result}, 32'h0223);
        // Random mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[3:0] == 0) idle(rv[6:4]);
            else issue(rv[9:8], rv[13:10], $urandom, $urandom, rv[25:16], rv[6:4], "R3 random mix");
        end
        idle(3'd0); idle(3'd0);
        @(negedge clk);
        // R11 reset mid-run
        do_reset();
        issue(0, 4'd7, 16'h0000, 16'h0, 0, 3'd0, "R11 after reset");
        idle(3'd1);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule